// File: doc/BRIEF.md
# Oversampled UART Receive Deserializer

This block turns an asynchronous serial line into parallel characters. An oversampling tick from an outside baud generator arrives at 16 or 8 times the bit rate, selected by a mode input. A falling edge on the idle-high line starts a tick counter. The start bit is checked again at its centre, so a short glitch is dropped as a false start. Every data, parity and stop bit after it is sampled once, at its own centre.

Each finished character appears on a one-cycle valid strobe. Data, parity-error, framing-error and break flags go out with it and hold until the next character. Word length (5 to 8 bits), parity (off, odd or even) and oversampling mode are set on inputs. The receiver copies them at the falling edge that opens a frame. A receive FIFO, host registers and the baud divisor sit in the blocks around this one.

Top module: `oversampled_uart_rx`

## Requirements
- R1: After reset `char_valid`, `char_data`, `parity_err`, `framing_err` and `break_det` are all zero, and no character is produced while the line stays high.
- R2: With `os_mode_8x` = 0 a bit lasts 16 ticks. If the falling edge is first driven just after tick k, the start bit is sampled on tick k+8. The stop bit is sampled on tick k+8+16·(n+p+1), where n is the word length and p is 1 when parity is on. `char_valid` is high in the clock cycle after that tick.
- R3: With `os_mode_8x` = 1 a bit lasts 8 ticks. The start bit is sampled on tick k+4 and the stop bit on tick k+4+8·(n+p+1).
- R4: If the line is high at the start-bit centre sample, the frame is a false start. The receiver returns to waiting for a falling edge and delivers no character.
- R5: `word_len` 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Data arrives least significant bit first and lands in `char_data[0]` upward. Bits above the word length are zero.
- R6: With `parity_en` = 1, one parity bit follows the data. `parity_odd` = 1 expects an odd count of ones over data plus parity bit, and 0 expects an even count. `parity_err` is set on a mismatch. With `parity_en` = 0 no parity bit is taken and `parity_err` is 0.
- R7: `framing_err` is 1 when the stop-bit sample is low.
- R8: `break_det` is 1 when every data, parity and stop sample of the frame is low. After any stop sample the receiver waits for the line to go high before it arms again, so a line held low gives exactly one character.
- R9: Configuration inputs are copied at the falling edge that opens a frame. Changes during the frame do not affect that frame's length, timing or parity check.
- R10: `char_valid` is high for exactly one clock per character. `char_data` and the three flags hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-clock oversampling tick, 16x or 8x the bit rate |
| os_mode_8x | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_en | input | 1 | 1 = a parity bit follows the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| char_valid | output | 1 | One-cycle strobe, a character is ready |
| char_data | output | 8 | Received character, upper bits zero for short words |
| parity_err | output | 1 | Parity mismatch for the current character |
| framing_err | output | 1 | Stop bit was sampled low |
| break_det | output | 1 | All samples of the frame were low |

## Verification
Every result is timed in ticks, counted from the tick after which the bench drives the falling edge. The stop sample falls on tick k+half+period·(n+p+1), and the strobe appears in the following clock cycle. The bench keeps a tick counter that is updated on the falling clock edge. It logs the counter value on the cycle where the strobe is seen and compares it exactly with that formula, for both oversampling modes. Line changes are driven right after a tick, so the two-stage synchronizer settles several clocks before the next tick is consumed. The "no character" results (false starts, held break) are checked by counting strobes over a window longer than a full frame.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    localparam int MAX_BITS = 8;
    localparam int IDX_W    = $clog2(MAX_BITS);

    // Receiver phase; the reset encoding must stay zero (waits for idle line).
    typedef enum logic [2:0] {
        RX_WAIT_HIGH = 3'd0,
        RX_IDLE      = 3'd1,
        RX_START     = 3'd2,
        RX_DATA      = 3'd3,
        RX_PARITY    = 3'd4,
        RX_STOP      = 3'd5
    } rx_state_e;

    // Frame setup, latched when a frame opens.
    typedef struct packed {
        logic       mode_8x;
        logic [1:0] word_len;
        logic       par_en;
        logic       par_odd;
    } rx_cfg_t;

    // Every registered value of the receiver.
    typedef struct packed {
        rx_state_e             state;
        rx_cfg_t               cfg;
        logic [IDX_W-1:0]      bit_idx;
        logic [MAX_BITS-1:0]   shift;
        logic                  par_bit;
        logic                  seen_high;
        logic                  valid;
        logic [MAX_BITS-1:0]   data;
        logic                  perr;
        logic                  ferr;
        logic                  brk;
    } rx_regs_t;

    // Index of the last data bit for a word-length code (5..8 bits).
    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] wl);
        return IDX_W'(4) + IDX_W'(wl);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    // Reset to the idle (high) line level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rx_tick_timer.sv
`timescale 1ns/1ps
module rx_tick_timer #(
    parameter int OS_FULL    = 16,
    parameter int OS_REDUCED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic use_reduced,
    output logic half_hit,
    output logic full_hit
);

    localparam int CNT_W = $clog2(OS_FULL);
    localparam logic [CNT_W-1:0] FULL_HI_LAST = CNT_W'(OS_FULL - 1);
    localparam logic [CNT_W-1:0] HALF_HI_LAST = CNT_W'(OS_FULL / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LO_LAST = CNT_W'(OS_REDUCED - 1);
    localparam logic [CNT_W-1:0] HALF_LO_LAST = CNT_W'(OS_REDUCED / 2 - 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full_last;
    logic [CNT_W-1:0] half_last;

    always_comb begin
        full_last = use_reduced ? FULL_LO_LAST : FULL_HI_LAST;
        half_last = use_reduced ? HALF_LO_LAST : HALF_HI_LAST;
        half_hit  = tick && (cnt_q == half_last);
        full_hit  = tick && (cnt_q == full_last);
        if (clear)     cnt_d = '0;
        else if (tick) cnt_d = cnt_q + CNT_W'(1);
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rx_frame_check.sv
`timescale 1ns/1ps
module rx_frame_check #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_bit,
    input  logic              seen_high,
    output logic              perr,
    output logic              ferr,
    output logic              brk
);

    // Unused upper data bits are already zero, so a plain reduction works.
    always_comb begin
        perr = par_en && ((^data ^ par_bit) != par_odd);
        ferr = !stop_bit;
        brk  = !(seen_high || stop_bit);
    end

endmodule

// File: rtl/oversampled_uart_rx.sv
`timescale 1ns/1ps
module oversampled_uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OS_FULL     = 16,
    parameter int OS_REDUCED  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       os_mode_8x,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic       parity_odd,
    input  logic       rx_serial,
    output logic       char_valid,
    output logic [7:0] char_data,
    output logic       parity_err,
    output logic       framing_err,
    output logic       break_det
);

    rx_regs_t st_d;
    rx_regs_t st_q;

    logic line;
    logic half_hit;
    logic full_hit;
    logic tmr_clear;
    logic chk_perr;
    logic chk_ferr;
    logic chk_brk;

    // Latched setup, brought out for the bound checker.
    logic [1:0] cur_word_len;
    logic       cur_par_en;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .dout  (line)
    );

    rx_tick_timer #(.OS_FULL(OS_FULL), .OS_REDUCED(OS_REDUCED)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .clear       (tmr_clear),
        .use_reduced (st_q.cfg.mode_8x),
        .half_hit    (half_hit),
        .full_hit    (full_hit)
    );

    rx_frame_check #(.DATA_W(MAX_BITS)) u_check (
        .data      (st_q.shift),
        .par_bit   (st_q.par_bit),
        .par_en    (st_q.cfg.par_en),
        .par_odd   (st_q.cfg.par_odd),
        .stop_bit  (line),
        .seen_high (st_q.seen_high),
        .perr      (chk_perr),
        .ferr      (chk_ferr),
        .brk       (chk_brk)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        tmr_clear  = 1'b0;
        unique case (st_q.state)
            RX_WAIT_HIGH: begin
                tmr_clear = 1'b1;
                if (line) st_d.state = RX_IDLE;
            end
            RX_IDLE: begin
                tmr_clear = 1'b1;
                if (!line) begin
                    st_d.state         = RX_START;
                    st_d.cfg.mode_8x   = os_mode_8x;
                    st_d.cfg.word_len  = word_len;
                    st_d.cfg.par_en    = parity_en;
                    st_d.cfg.par_odd   = parity_odd;
                    st_d.bit_idx       = '0;
                    st_d.shift         = '0;
                    st_d.par_bit       = 1'b0;
                    st_d.seen_high     = 1'b0;
                end
            end
            RX_START: begin
                if (half_hit) begin
                    tmr_clear  = 1'b1;
                    st_d.state = line ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: begin
                if (full_hit) begin
                    tmr_clear                = 1'b1;
                    st_d.shift[st_q.bit_idx] = line;
                    st_d.seen_high           = st_q.seen_high | line;
                    if (st_q.bit_idx == last_index(st_q.cfg.word_len))
                        st_d.state = st_q.cfg.par_en ? RX_PARITY : RX_STOP;
                    else
                        st_d.bit_idx = st_q.bit_idx + IDX_W'(1);
                end
            end
            RX_PARITY: begin
                if (full_hit) begin
                    tmr_clear      = 1'b1;
                    st_d.par_bit   = line;
                    st_d.seen_high = st_q.seen_high | line;
                    st_d.state     = RX_STOP;
                end
            end
            RX_STOP: begin
                if (full_hit) begin
                    tmr_clear  = 1'b1;
                    st_d.valid = 1'b1;
                    st_d.data  = st_q.shift;
                    st_d.perr  = chk_perr;
                    st_d.ferr  = chk_ferr;
                    st_d.brk   = chk_brk;
                    st_d.state = RX_WAIT_HIGH;
                end
            end
            default: begin
                tmr_clear  = 1'b1;
                st_d.state = RX_WAIT_HIGH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign char_valid   = st_q.valid;
    assign char_data    = st_q.data;
    assign parity_err   = st_q.perr;
    assign framing_err  = st_q.ferr;
    assign break_det    = st_q.brk;
    assign cur_word_len = st_q.cfg.word_len;
    assign cur_par_en   = st_q.cfg.par_en;

endmodule

// File: rtl/rx_checker.sv
`timescale 1ns/1ps
module rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       char_valid,
    input logic [7:0] char_data,
    input logic       parity_err,
    input logic       framing_err,
    input logic       break_det,
    input logic [1:0] cur_word_len,
    input logic       cur_par_en
);

    // R10: the strobe never lasts two cycles.
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R10: outputs hold between strobes.
    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |-> $stable({char_data, parity_err, framing_err, break_det}));

    // R8: a break frame is all zero and also a framing error.
    assert_break_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && break_det) |-> (framing_err && char_data == 8'h00));

    // R5: nothing above the configured word length.
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> ((char_data >> ({2'b00, cur_word_len} + 4'd5)) == 8'h00));

    // R6: no parity error without a parity bit.
    assert_no_parity_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !cur_par_en) |-> !parity_err);

endmodule

bind oversampled_uart_rx rx_checker u_rx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .char_valid   (char_valid),
    .char_data    (char_data),
    .parity_err   (parity_err),
    .framing_err  (framing_err),
    .break_det    (break_det),
    .cur_word_len (cur_word_len),
    .cur_par_en   (cur_par_en)
);

// File: tb/oversampled_uart_rx_bench.sv
`timescale 1ns/1ps
module oversampled_uart_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       os_mode_8x = 1'b0;
    logic [1:0] word_len = 2'b11;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rx_serial = 1'b1;
    logic       char_valid;
    logic [7:0] char_data;
    logic       parity_err;
    logic       framing_err;
    logic       break_det;

    oversampled_uart_rx u_oversampled_uart_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .os_mode_8x  (os_mode_8x),
        .word_len    (word_len),
        .parity_en   (parity_en),
        .parity_odd  (parity_odd),
        .rx_serial   (rx_serial),
        .char_valid  (char_valid),
        .char_data   (char_data),
        .parity_err  (parity_err),
        .framing_err (framing_err),
        .break_det   (break_det)
    );

    always #4 clk = ~clk;

    // Tick every 4 clocks.
    int div = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            div     <= 0;
            os_tick <= 1'b0;
        end else begin
            div     <= (div == 3) ? 0 : div + 1;
            os_tick <= (div == 3);
        end
    end

    // Monitor on the falling edge.
    int         tick_cnt = 0;
    int         n_chars = 0;
    int         v_tick = 0;
    logic [7:0] v_data = 8'h00;
    logic       v_perr = 1'b0;
    logic       v_ferr = 1'b0;
    logic       v_brk = 1'b0;
    event       tick_ev;

    always @(negedge clk) begin
        if (os_tick) begin
            tick_cnt = tick_cnt + 1;
            -> tick_ev;
        end
        if (char_valid) begin
            n_chars = n_chars + 1;
            v_tick  = tick_cnt;
            v_data  = char_data;
            v_perr  = parity_err;
            v_ferr  = framing_err;
            v_brk   = break_det;
        end
    end

    int n_tests = 0;
    int n_fail = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(tick_ev);
    endtask

    task automatic set_cfg(input bit m8, input logic [1:0] wl, input bit pe, input bit po);
        os_mode_8x = m8;
        word_len   = wl;
        parity_en  = pe;
        parity_odd = po;
    endtask

    task automatic send_frame(input logic [7:0] d, input int nbits, input bit pe, input bit po,
                              input bit bad_par, input bit stop_lvl, input int per, output int k);
        logic [7:0] mask;
        logic       p;
        mask = 8'hFF >> (8 - nbits);
        @(tick_ev);
        k = tick_cnt;
        rx_serial = 1'b0;
        wait_ticks(per);
        for (int i = 0; i < nbits; i++) begin
            rx_serial = d[i];
            wait_ticks(per);
        end
        if (pe) begin
            p = (^(d & mask)) ^ po ^ bad_par;
            rx_serial = p;
            wait_ticks(per);
        end
        rx_serial = stop_lvl;
        wait_ticks(per);
        rx_serial = 1'b1;
        wait_ticks(2);
    endtask

    task automatic expect_char(input string req, input int n_before, input int k, input int half,
                               input int per, input int nfield, input logic [7:0] d,
                               input bit perr, input bit ferr, input bit brk);
        check_eq(req, "character count", n_chars, n_before + 1);
        check_eq(req, "stop sample tick", v_tick, k + half + per * (nfield + 1));
        check_eq(req, "data", int'(v_data), int'(d));
        check_eq(req, "parity_err", int'(v_perr), int'(perr));
        check_eq(req, "framing_err", int'(v_ferr), int'(ferr));
        check_eq(req, "break_det", int'(v_brk), int'(brk));
    endtask

    // R1: reset values, quiet idle line.
    task automatic t_reset();
        @(negedge clk);
        check_eq("R1", "char_valid", int'(char_valid), 0);
        check_eq("R1", "char_data", int'(char_data), 0);
        check_eq("R1", "flags", int'({parity_err, framing_err, break_det}), 0);
        wait_ticks(40);
        check_eq("R1", "no char on idle line", n_chars, 0);
    endtask

    // R2 / R10: 16x 8N1, back to back, strobe width and hold.
    task automatic t_basic16();
        int k;
        int n0;
        set_cfg(1'b0, 2'b11, 1'b0, 1'b0);
        n0 = n_chars;
        send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, k);
        expect_char("R2", n0, k, 8, 16, 8, 8'hA5, 1'b0, 1'b0, 1'b0);
        n0 = n_chars;
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, k);
        expect_char("R2", n0, k, 8, 16, 8, 8'h3C, 1'b0, 1'b0, 1'b0);
        wait_ticks(20);
        check_eq("R10", "data held", int'(char_data), 8'h3C);
        check_eq("R10", "single strobe per char", n_chars, n0 + 1);
    endtask

    // R5: each word length, upper bits zero.
    task automatic t_word_lengths();
        int k;
        int n0;
        for (int wl = 0; wl < 4; wl++) begin
            set_cfg(1'b0, 2'(wl), 1'b0, 1'b0);
            n0 = n_chars;
            send_frame(8'hD6, 5 + wl, 1'b0, 1'b0, 1'b0, 1'b1, 16, k);
            expect_char("R5", n0, k, 8, 16, 5 + wl, 8'hD6 & (8'hFF >> (3 - wl)),
                        1'b0, 1'b0, 1'b0);
        end
    endtask

    // R6: even and odd parity, good and bad.
    task automatic t_parity();
        int k;
        int n0;
        set_cfg(1'b0, 2'b11, 1'b1, 1'b0);
        n0 = n_chars;
        send_frame(8'h5B, 8, 1'b1, 1'b0, 1'b0, 1'b1, 16, k);
        expect_char("R6", n0, k, 8, 16, 9, 8'h5B, 1'b0, 1'b0, 1'b0);
        n0 = n_chars;
        send_frame(8'h5B, 8, 1'b1, 1'b0, 1'b1, 1'b1, 16, k);
        expect_char("R6", n0, k, 8, 16, 9, 8'h5B, 1'b1, 1'b0, 1'b0);
        set_cfg(1'b0, 2'b10, 1'b1, 1'b1);
        n0 = n_chars;
        send_frame(8'h4B, 7, 1'b1, 1'b1, 1'b0, 1'b1, 16, k);
        expect_char("R6", n0, k, 8, 16, 8, 8'h4B, 1'b0, 1'b0, 1'b0);
        n0 = n_chars;
        send_frame(8'h4B, 7, 1'b1, 1'b1, 1'b1, 1'b1, 16, k);
        expect_char("R6", n0, k, 8, 16, 8, 8'h4B, 1'b1, 1'b0, 1'b0);
    endtask

    // R3: 8x mode timing.
    task automatic t_mode8();
        int k;
        int n0;
        set_cfg(1'b1, 2'b11, 1'b0, 1'b0);
        n0 = n_chars;
        send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1, 8, k);
        expect_char("R3", n0, k, 4, 8, 8, 8'h96, 1'b0, 1'b0, 1'b0);
        set_cfg(1'b1, 2'b01, 1'b1, 1'b0);
        n0 = n_chars;
        send_frame(8'h2D, 6, 1'b1, 1'b0, 1'b0, 1'b1, 8, k);
        expect_char("R3", n0, k, 4, 8, 7, 8'h2D, 1'b0, 1'b0, 1'b0);
    endtask

    // R4: glitches shorter than half a bit are dropped.
    task automatic t_false_start();
        int k;
        int n0;
        set_cfg(1'b0, 2'b11, 1'b0, 1'b0);
        n0 = n_chars;
        @(tick_ev);
        rx_serial = 1'b0;
        wait_ticks(7);
        rx_serial = 1'b1;
        wait_ticks(200);
        check_eq("R4", "16x glitch of 7 ticks", n_chars, n0);
        set_cfg(1'b1, 2'b11, 1'b0, 1'b0);
        @(tick_ev);
        rx_serial = 1'b0;
        wait_ticks(3);
        rx_serial = 1'b1;
        wait_ticks(120);
        check_eq("R4", "8x glitch of 3 ticks", n_chars, n0);
        set_cfg(1'b0, 2'b11, 1'b0, 1'b0);
        send_frame(8'h69, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, k);
        expect_char("R4", n0, k, 8, 16, 8, 8'h69, 1'b0, 1'b0, 1'b0);
    endtask

    // R7: low stop bit.
    task automatic t_framing();
        int k;
        int n0;
        set_cfg(1'b0, 2'b11, 1'b0, 1'b0);
        n0 = n_chars;
        send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16, k);
        expect_char("R7", n0, k, 8, 16, 8, 8'h55, 1'b0, 1'b1, 1'b0);
    endtask

    // R8: line held low gives a single break character.
    task automatic t_break();
        int k;
        int n0;
        set_cfg(1'b0, 2'b11, 1'b0, 1'b0);
        n0 = n_chars;
        @(tick_ev);
        k = tick_cnt;
        rx_serial = 1'b0;
        wait_ticks(400);
        expect_char("R8", n0, k, 8, 16, 8, 8'h00, 1'b0, 1'b1, 1'b1);
        rx_serial = 1'b1;
        wait_ticks(4);
        n0 = n_chars;
        send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16, k);
        expect_char("R8", n0, k, 8, 16, 8, 8'h81, 1'b0, 1'b0, 1'b0);
    endtask

    // R9: setup changes mid-frame are ignored.
    task automatic t_cfg_latch();
        int k;
        int n0;
        set_cfg(1'b0, 2'b11, 1'b1, 1'b0);
        n0 = n_chars;
        fork
            send_frame(8'hC3, 8, 1'b1, 1'b0, 1'b0, 1'b1, 16, k);
            begin
                wait_ticks(20);
                set_cfg(1'b1, 2'b00, 1'b0, 1'b1);
            end
        join
        expect_char("R9", n0, k, 8, 16, 9, 8'hC3, 1'b0, 1'b0, 1'b0);
        set_cfg(1'b0, 2'b11, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic16();
        t_word_lengths();
        t_parity();
        t_mode8();
        t_false_start();
        t_framing();
        t_break();
        t_cfg_latch();
        summary();
        $finish;
    end

endmodule